// File: doc/BRIEF.md
# Burst Address Generator with Dual Strobes

This block produces the word address presented to a synchronous burst memory array. An external address is captured on a rising clock edge whenever one of two start strobes is asserted: one from the processor side and one from the memory controller side. After that first beat, the two least significant address bits are stepped internally on each cycle in which the advance input is high. The upper address bits stay fixed for the whole burst.

A four-beat burst walks its low bits in one of two orders. In linear order the bits count up from the loaded start value and wrap modulo four. In interleaved order they equal the start bits XOR the beat count. The order input is sampled together with the address, so it is fixed for the whole burst. Holding the order input low selects interleaved order, which is the default for a board that leaves the pin unconnected.

Because a strobe can load a fresh address on every cycle with no idle cycle in between, bursting is optional. The chip enable gates both strobes. A processor strobe is ignored while the enable is low. A controller strobe with the enable low ends the current burst instead of loading an address.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is low, and on the first cycle after it, `addr_out` is 0, `beat_idx` is 0, `burst_active` is 0 and `load_from_ctrl` is 0.
- R2: When `strobe_proc` and `chip_en` are both high at an edge, `addr_out` equals the sampled `addr_in` after that edge, `beat_idx` is 0, `burst_active` is 1 and `load_from_ctrl` is 0. This holds on every consecutive cycle.
- R3: When `strobe_ctrl` and `chip_en` are high and `strobe_proc` is low, the address loads as in R2 and `load_from_ctrl` becomes 1.
- R4: When both strobes are high with `chip_en` high, the processor strobe wins and `load_from_ctrl` becomes 0.
- R5: When `strobe_proc` is high and `chip_en` is low, no load takes place: `addr_out` does not take `addr_in`, and `load_from_ctrl` keeps its value.
- R6: When `strobe_ctrl` is high and `chip_en` is low (and no load occurs), `burst_active` becomes 0. `addr_out` and `beat_idx` hold their values.
- R7: When a burst is active and `advance` is high with no strobe event, `beat_idx` increments modulo 4. Bits above bit 1 of `addr_out` never change without a load.
- R8: In linear order (`order_linear`=1 at the load), `addr_out[1:0]` = (start bits + `beat_idx`) mod 4.
- R9: In interleaved order (`order_linear`=0 at the load), `addr_out[1:0]` = start bits XOR `beat_idx`.
- R10: `advance` is ignored on a cycle in which a strobe loads an address, so `beat_idx` is 0 after that load.
- R11: When `advance` is low, or when no burst is active, `beat_idx` and `addr_out` hold.
- R12: A change of `order_linear` in the middle of a burst has no effect until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_en | input | 1 | Chip enable that gates both strobes |
| strobe_proc | input | 1 | Processor-side burst start strobe (priority) |
| strobe_ctrl | input | 1 | Controller-side burst start strobe |
| advance | input | 1 | Step to the next beat |
| order_linear | input | 1 | 1 selects linear order, 0 selects interleaved order; sampled at load |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current array word address |
| beat_idx | output | BEAT_W | Beat count within the burst |
| burst_active | output | 1 | A burst is in progress |
| load_from_ctrl | output | 1 | The last load came from the controller strobe |

## Verification
Every result of this block is due exactly one clock edge after the stimulus that causes it. This applies to loads, beat steps, deselects and reset. No output depends combinationally on any input. The bench drives inputs on the falling edge and samples all outputs 2 ns after the following rising edge, so each table row is judged on the edge that consumes it. A reset applied in the middle of a burst is checked the same way, one edge after reset is asserted.

// File: rtl/burst_addr_pkg.sv
// Shared types for the burst address generator.
package burst_addr_pkg;
    // Per-cycle action chosen by the strobe arbiter.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_STEP  = 2'd2,
        ACT_DESEL = 2'd3
    } act_e;

    // Origin of the most recent load.
    typedef enum logic {
        SRC_PROC = 1'b0,
        SRC_CTRL = 1'b1
    } src_e;

    // Beat ordering of a burst.
    typedef enum logic {
        ORD_INTLV  = 1'b0,
        ORD_LINEAR = 1'b1
    } order_e;
endpackage

// File: rtl/strobe_arbiter.sv
// Strobe arbiter: decides each cycle whether to load, step, deselect or hold.
// Assumes: the processor strobe has priority and is gated by chip enable;
// a controller strobe with chip enable low deselects; advance acts only
// when no strobe event occurs and a burst is active.
module strobe_arbiter
    import burst_addr_pkg::*;
(
    input  logic chip_en,
    input  logic strobe_proc,
    input  logic strobe_ctrl,
    input  logic advance,
    input  logic active,
    output act_e act,
    output src_e src
);
    // Priority decode of the strobe and advance inputs.
    always_comb begin
        act = ACT_HOLD;
        src = SRC_PROC;
        if (strobe_proc && chip_en) begin
            act = ACT_LOAD;
            src = SRC_PROC;
        end else if (strobe_ctrl && chip_en) begin
            act = ACT_LOAD;
            src = SRC_CTRL;
        end else if (strobe_ctrl) begin
            act = ACT_DESEL;
        end else if (advance && active) begin
            act = ACT_STEP;
        end
    end
endmodule

// File: rtl/beat_counter.sv
// Beat counter: clears on a load and increments modulo 2**BEAT_W on a step.
// Assumes: act comes from strobe_arbiter; every other action holds the count.
module beat_counter
    import burst_addr_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  act_e              act,
    output logic [BEAT_W-1:0] beat
);
    // Update the beat count according to the chosen action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat <= '0;
        end else begin
            case (act)
                ACT_LOAD: beat <= '0;
                ACT_STEP: beat <= beat + 1'b1;
                default:  beat <= beat;
            endcase
        end
    end
endmodule

// File: rtl/addr_mapper.sv
// Address mapper: turns the start bits and the beat count into the low
// address bits, using either a wrapping add or a per-bit XOR.
// Assumes: the order input is the value latched at load.
module addr_mapper
    import burst_addr_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start,
    input  logic [BEAT_W-1:0] beat,
    input  order_e            order,
    output logic [BEAT_W-1:0] low
);
    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] xor_low;

    // The wrapping add drops the carry out of the burst field.
    assign lin_low = start + beat;

    // The interleaved sequence is built one bit at a time.
    for (genvar i = 0; i < BEAT_W; i++) begin : g_xor
        assign xor_low[i] = start[i] ^ beat[i];
    end

    // Pick the sequence for the latched order.
    always_comb begin
        low = (order == ORD_LINEAR) ? lin_low : xor_low;
    end
endmodule

// File: rtl/burst_addr_gen.sv
// Burst address generator top: holds the upper address, the start bits,
// the latched order and the burst state, and combines them with the beat
// counter to form the array address.
// Assumes: synchronous active-low reset; every output comes from registers
// through logic only, so each result appears one edge after its cause.
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en,
    input  logic              strobe_proc,
    input  logic              strobe_ctrl,
    input  logic              advance,
    input  logic              order_linear,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [BEAT_W-1:0] beat_idx,
    output logic              burst_active,
    output logic              load_from_ctrl
);
    localparam int UPPER_W = ADDR_W - BEAT_W;

    act_e               act;
    src_e               src_next;
    src_e               src_q;
    order_e             order_q;
    logic [UPPER_W-1:0] upper_q;
    logic [BEAT_W-1:0]  start_q;
    logic [BEAT_W-1:0]  beat;
    logic [BEAT_W-1:0]  low;
    logic               active_q;

    strobe_arbiter u_arb (
        .chip_en     (chip_en),
        .strobe_proc (strobe_proc),
        .strobe_ctrl (strobe_ctrl),
        .advance     (advance),
        .active      (active_q),
        .act         (act),
        .src         (src_next)
    );

    beat_counter #(.BEAT_W(BEAT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act),
        .beat  (beat)
    );

    addr_mapper #(.BEAT_W(BEAT_W)) u_map (
        .start (start_q),
        .beat  (beat),
        .order (order_q),
        .low   (low)
    );

    // Capture the address, order and source on a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            start_q <= '0;
            order_q <= ORD_INTLV;
            src_q   <= SRC_PROC;
        end else if (act == ACT_LOAD) begin
            upper_q <= addr_in[ADDR_W-1:BEAT_W];
            start_q <= addr_in[BEAT_W-1:0];
            order_q <= order_linear ? ORD_LINEAR : ORD_INTLV;
            src_q   <= src_next;
        end
    end

    // Set the burst-active flag on a load; clear it on a deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
        end else if (act == ACT_LOAD) begin
            active_q <= 1'b1;
        end else if (act == ACT_DESEL) begin
            active_q <= 1'b0;
        end
    end

    assign addr_out       = {upper_q, low};
    assign beat_idx       = beat;
    assign burst_active   = active_q;
    assign load_from_ctrl = (src_q == SRC_CTRL);
endmodule

// File: rtl/burst_addr_gen_chk.sv
// Checker for burst_addr_gen, bound to every instance of it. It looks only
// at the ports and relates them across one clock edge.
module burst_addr_gen_chk #(
    parameter int ADDR_W = 19,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chip_en,
    input logic              strobe_proc,
    input logic              strobe_ctrl,
    input logic              advance,
    input logic              order_linear,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic [BEAT_W-1:0] beat_idx,
    input logic              burst_active,
    input logic              load_from_ctrl
);
    logic loading;
    assign loading = (strobe_proc || strobe_ctrl) && chip_en;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (beat_idx == '0 && !burst_active && !load_from_ctrl));

    // R2
    proc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_proc && chip_en) |=> (addr_out == $past(addr_in) && beat_idx == '0
                                      && burst_active && !load_from_ctrl));

    // R3
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_ctrl && chip_en && !strobe_proc) |=> (addr_out == $past(addr_in)
                                                      && load_from_ctrl));

    // R4
    proc_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_proc && strobe_ctrl && chip_en) |=> !load_from_ctrl);

    // R5
    gated_proc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_proc && !strobe_ctrl && !chip_en) |=> $stable(load_from_ctrl));

    // R6
    deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_ctrl && !chip_en) |=> (!burst_active && $stable(addr_out)
                                       && $stable(beat_idx)));

    // R7
    beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_active && advance && !strobe_ctrl && !loading)
        |=> beat_idx == BEAT_W'($past(beat_idx) + 1'b1));

    // R7
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !loading |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!loading && (!advance || !burst_active)) |=> ($stable(beat_idx)
                                                       && $stable(addr_out)));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (.*);

// File: tb/burst_addr_gen_tb.sv
// Bench for burst_addr_gen: a vector table walked by one loop, followed by
// directed checks for reset.
module burst_addr_gen_tb;
    localparam int ADDR_W = 19;
    localparam int BEAT_W = 2;

    typedef struct packed {
        logic              pr;
        logic              ct;
        logic              ce;
        logic              adv;
        logic              lin;
        logic [ADDR_W-1:0] a;
        logic [ADDR_W-1:0] ea;
        logic [BEAT_W-1:0] eb;
        logic              eact;
        logic              esrc;
    } vec_t;

    localparam int NV = 17;
    // pr ct ce adv lin addr_in   exp_addr  beat act src
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b1,1'b0,1'b1, 19'h12345, 19'h12345, 2'd0, 1'b1, 1'b0}, // R2 R8
        '{1'b0,1'b0,1'b1,1'b1,1'b1, 19'h00000, 19'h12346, 2'd1, 1'b1, 1'b0}, // R7 R8
        '{1'b0,1'b0,1'b1,1'b1,1'b1, 19'h00000, 19'h12347, 2'd2, 1'b1, 1'b0}, // R8
        '{1'b0,1'b0,1'b1,1'b1,1'b1, 19'h00000, 19'h12344, 2'd3, 1'b1, 1'b0}, // R8 wrap
        '{1'b0,1'b0,1'b1,1'b1,1'b1, 19'h00000, 19'h12345, 2'd0, 1'b1, 1'b0}, // R7 wrap
        '{1'b0,1'b0,1'b1,1'b0,1'b1, 19'h00000, 19'h12345, 2'd0, 1'b1, 1'b0}, // R11
        '{1'b0,1'b1,1'b1,1'b0,1'b0, 19'h0ABCE, 19'h0ABCE, 2'd0, 1'b1, 1'b1}, // R3
        '{1'b0,1'b0,1'b1,1'b1,1'b0, 19'h00000, 19'h0ABCF, 2'd1, 1'b1, 1'b1}, // R9
        '{1'b0,1'b0,1'b1,1'b1,1'b0, 19'h00000, 19'h0ABCC, 2'd2, 1'b1, 1'b1}, // R9
        '{1'b0,1'b0,1'b1,1'b1,1'b0, 19'h00000, 19'h0ABCD, 2'd3, 1'b1, 1'b1}, // R9
        '{1'b1,1'b1,1'b1,1'b1,1'b1, 19'h7FFFF, 19'h7FFFF, 2'd0, 1'b1, 1'b0}, // R4 R10
        '{1'b0,1'b0,1'b1,1'b1,1'b0, 19'h00000, 19'h7FFFC, 2'd1, 1'b1, 1'b0}, // R12 R7
        '{1'b1,1'b0,1'b0,1'b1,1'b0, 19'h11111, 19'h7FFFD, 2'd2, 1'b1, 1'b0}, // R5
        '{1'b0,1'b1,1'b0,1'b0,1'b0, 19'h22222, 19'h7FFFD, 2'd2, 1'b0, 1'b0}, // R6
        '{1'b0,1'b0,1'b1,1'b1,1'b0, 19'h00000, 19'h7FFFD, 2'd2, 1'b0, 1'b0}, // R11
        '{1'b1,1'b0,1'b1,1'b0,1'b0, 19'h00003, 19'h00003, 2'd0, 1'b1, 1'b0}, // R2 R9
        '{1'b0,1'b1,1'b1,1'b1,1'b1, 19'h00000, 19'h00000, 2'd0, 1'b1, 1'b1}  // R2 R3 R10
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              chip_en = 1'b0;
    logic              strobe_proc = 1'b0;
    logic              strobe_ctrl = 1'b0;
    logic              advance = 1'b0;
    logic              order_linear = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic [ADDR_W-1:0] addr_out;
    logic [BEAT_W-1:0] beat_idx;
    logic              burst_active;
    logic              load_from_ctrl;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .chip_en        (chip_en),
        .strobe_proc    (strobe_proc),
        .strobe_ctrl    (strobe_ctrl),
        .advance        (advance),
        .order_linear   (order_linear),
        .addr_in        (addr_in),
        .addr_out       (addr_out),
        .beat_idx       (beat_idx),
        .burst_active   (burst_active),
        .load_from_ctrl (load_from_ctrl)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input logic [ADDR_W-1:0] ea,
                             input logic [BEAT_W-1:0] eb, input logic eact, input logic esrc);
        check({tag, " addr"},   32'(addr_out),       32'(ea));
        check({tag, " beat"},   32'(beat_idx),       32'(eb));
        check({tag, " active"}, 32'(burst_active),   32'(eact));
        check({tag, " src"},    32'(load_from_ctrl), 32'(esrc));
    endtask

    initial begin
        // R1: reset held for several edges
        repeat (3) @(posedge clk);
        #2 check_all("R1 reset", '0, '0, 1'b0, 1'b0);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            strobe_proc  = VECS[i].pr;
            strobe_ctrl  = VECS[i].ct;
            chip_en      = VECS[i].ce;
            advance      = VECS[i].adv;
            order_linear = VECS[i].lin;
            addr_in      = VECS[i].a;
            @(posedge clk);
            #2 check_all($sformatf("vec %0d", i), VECS[i].ea, VECS[i].eb,
                         VECS[i].eact, VECS[i].esrc);
        end

        // R1: reset applied in the middle of a burst after a controller load
        @(negedge clk);
        strobe_proc = 1'b0; strobe_ctrl = 1'b0; advance = 1'b1;
        rst_n = 1'b0;
        @(posedge clk);
        #2 check_all("R1 mid reset", '0, '0, 1'b0, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        // R11: advance with no burst active after reset
        @(posedge clk);
        #2 check_all("R11 idle after reset", '0, '0, 1'b0, 1'b0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule